// File: doc/BRIEF.md
# Register-Aliased Network Port Unit

This unit couples an in-order issue pipeline model to four inter-tile network channels. Four consecutive register numbers are aliased onto the channels. A source operand that names one of them takes its value from the head of that channel's input queue and consumes the word. A destination that names one of them sends the instruction's result into that channel's output queue. Every other register number goes to an ordinary register file that lives outside the block, reached through a combinational read port and a write-back port.

Instructions are offered on a valid/ready issue port. The ready signal is the register-fetch stall: it drops while a named input queue is empty, or while a targeted output queue has no room left after counting the results still in flight. Ready may depend on the offered instruction fields but never on `in_valid`. An accepted instruction is committed: it moves through `NSTG` stages and is never squashed. Its result is ready `lat` stages after issue. From that point any stage may hand it to its output queue; it does not have to wait for write-back. For each queue, the oldest pending result is always served first, so words leave in program order. A dual-destination bit copies the result to channel 0 as well.

Both network sides use valid/ready. An input channel accepts a word in any cycle in which its queue is not full. An output channel keeps its word and data steady until the consumer raises ready. The result of the pipeline model is the XOR of the two operands and an immediate; this stands in for the datapath.

Top module: `netport_regmap`

## Requirements
- R1: Registers 24, 25, 26 and 27 alias channels 0, 1, 2 and 3 in that order. Any other register number reads through `rf_ra_idx`/`rf_rb_idx` and never stalls issue on a queue.
- R2: Each accepted instruction removes one word from the input queue of every channel named by a source. If both sources name the same channel, only one word is removed, and it feeds both operands.
- R3: While a source names a channel whose input queue is empty, `in_ready` is 0 and nothing is consumed.
- R4: `in_ready` is 0 while, for a targeted channel, the output queue's word count plus the in-flight results bound for it reaches `DEPTH`.
- R5: The result is operand A XOR operand B XOR `in_imm`. A destination of 24..27 pushes the result into that channel's output queue.
- R6: With `in_dual` = 1 the result also goes to channel 0. When the destination is already 24, only one word is sent.
- R7: A result with latency L, issued at clock edge T to a channel with no older pending result, appears on `nout_valid` right after edge T+L.
- R8: For each channel, output words leave in issue order, whatever the latencies.
- R9: A destination outside 24..27 raises `rf_we` with `rf_wa` = destination and `rf_wd` = result during the cycle after edge T+NSTG-1.
- R10: After reset, `nin_ready` is all ones and `nout_valid` and `rf_we` are 0. A full input queue drops `nin_ready`. An output word with its data holds until taken.
- R11: A latency of 0 behaves as 1. A latency above `NSTG` behaves as `NSTG`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted (low = register-fetch stall) |
| in_src_a | input | 5 | Source register A |
| in_src_b | input | 5 | Source register B |
| in_dst | input | 5 | Destination register |
| in_dual | input | 1 | Also send the result to channel 0 |
| in_lat | input | LAT_W | Stages until the result is ready |
| in_imm | input | DW | Immediate folded into the result |
| rf_ra_idx | output | 5 | Register-file read index A |
| rf_rb_idx | output | 5 | Register-file read index B |
| rf_ra_data | input | DW | Register-file read data A |
| rf_rb_data | input | DW | Register-file read data B |
| rf_we | output | 1 | Register-file write enable at write-back |
| rf_wa | output | 5 | Register-file write index |
| rf_wd | output | DW | Register-file write data |
| nin_valid | input | 4 | Per-channel input word valid |
| nin_ready | output | 4 | Per-channel input queue not full |
| nin_data | input | 4*DW | Input words, channel k at bits k*DW |
| nout_valid | output | 4 | Per-channel output word valid |
| nout_ready | input | 4 | Per-channel consumer ready |
| nout_data | output | 4*DW | Output words, channel k at bits k*DW |

## Verification
Several output-queue captures can fall in the same cycle. A young short-latency result becomes ready while an older long-latency result bound for the same queue is still computing, and this can happen at the same edge that another channel captures and the issue port stalls on space. The bench provokes this with back-to-back issues of mixed latencies, dual destinations and throttled consumers. It judges the result by comparing every word that leaves each channel, in order, against a queue model fed by the bench at issue time. Directed runs pin down the exact cycle of early capture and write-back, and the stall that an empty input queue or a fully booked output queue causes.

// File: rtl/netport_pkg.sv
`timescale 1ns/1ps
package netport_pkg;
  localparam int unsigned NET_CNT = 4;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned NET_W   = 2;

  function automatic logic reg_is_net(input logic [REG_W-1:0] r, input logic [REG_W-1:0] base);
    return ({1'b0, r} >= {1'b0, base}) && ({1'b0, r} < ({1'b0, base} + (REG_W+1)'(NET_CNT)));
  endfunction

  function automatic logic [NET_W-1:0] reg_net(input logic [REG_W-1:0] r, input logic [REG_W-1:0] base);
    return NET_W'(r - base);
  endfunction

  function automatic logic [NET_CNT-1:0] net_onehot(input logic [NET_W-1:0] n);
    return NET_CNT'(1) << n;
  endfunction
endpackage

// File: rtl/netport_fifo.sv
`timescale 1ns/1ps
module netport_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH+1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_fire, rd_fire;

  assign wr_ready = (level != CW'(DEPTH));
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_ready && (level != '0);
  assign rd_data  = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_fire) begin
        mem[wptr] <= wr_data;
        wptr      <= bump(wptr);
      end
      if (rd_fire) rptr <= bump(rptr);
      case ({wr_fire, rd_fire})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/netport_decode.sv
`timescale 1ns/1ps
module netport_decode import netport_pkg::*; #(
  parameter int unsigned DW       = 32,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned SUMW     = 4,
  parameter logic [REG_W-1:0] BASE_REG = 5'd24
) (
  input  logic [REG_W-1:0]                src_a,
  input  logic [REG_W-1:0]                src_b,
  input  logic [REG_W-1:0]                dst,
  input  logic                            dual,
  input  logic [DW-1:0]                   imm,
  input  logic [NET_CNT-1:0]              in_empty,
  input  logic [NET_CNT-1:0][DW-1:0]      in_head,
  input  logic [NET_CNT-1:0][SUMW-1:0]    occ,
  input  logic [DW-1:0]                   rf_a_data,
  input  logic [DW-1:0]                   rf_b_data,
  output logic                            ok,
  output logic [NET_CNT-1:0]              need_mask,
  output logic [NET_CNT-1:0]              dst_mask,
  output logic                            rf_dst,
  output logic [DW-1:0]                   result
);
  logic             a_net, b_net, d_net;
  logic [NET_W-1:0] a_idx, b_idx, d_idx;
  logic [DW-1:0]    a_val, b_val;
  logic             space_ok;

  always_comb begin
    a_net = reg_is_net(src_a, BASE_REG);
    b_net = reg_is_net(src_b, BASE_REG);
    d_net = reg_is_net(dst, BASE_REG);
    a_idx = reg_net(src_a, BASE_REG);
    b_idx = reg_net(src_b, BASE_REG);
    d_idx = reg_net(dst, BASE_REG);

    need_mask = (a_net ? net_onehot(a_idx) : '0) | (b_net ? net_onehot(b_idx) : '0);
    dst_mask  = (d_net ? net_onehot(d_idx) : '0) | (dual ? NET_CNT'(1) : '0);
    rf_dst    = !d_net;

    space_ok = 1'b1;
    for (int k = 0; k < NET_CNT; k++) begin
      if (dst_mask[k] && (occ[k] >= SUMW'(DEPTH))) space_ok = 1'b0;
    end
    ok = space_ok && ((need_mask & in_empty) == '0);

    a_val  = a_net ? in_head[a_idx] : rf_a_data;
    b_val  = b_net ? in_head[b_idx] : rf_b_data;
    result = a_val ^ b_val ^ imm;
  end
endmodule

// File: rtl/netport_capture.sv
`timescale 1ns/1ps
module netport_capture #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NSTG = 4
) (
  input  logic [NSTG-1:0]         pend,
  input  logic [NSTG-1:0]         rdy,
  input  logic [NSTG-1:0][DW-1:0] data,
  input  logic                    space,
  output logic                    want,
  output logic                    push,
  output logic [DW-1:0]           push_data,
  output logic [NSTG-1:0]         clr
);
  // Higher stage index holds the older instruction; only the oldest pending
  // entry may be taken, so a ready younger result waits behind it.
  logic found;
  always_comb begin
    found     = 1'b0;
    want      = 1'b0;
    push_data = '0;
    clr       = '0;
    for (int i = NSTG-1; i >= 0; i--) begin
      if (!found && pend[i]) begin
        found = 1'b1;
        if (rdy[i]) begin
          want      = 1'b1;
          push_data = data[i];
          clr[i]    = space;
        end
      end
    end
    push = want && space;
  end
endmodule

// File: rtl/netport_regmap.sv
`timescale 1ns/1ps
module netport_regmap import netport_pkg::*; #(
  parameter int unsigned      DW       = 32,
  parameter int unsigned      DEPTH    = 4,
  parameter int unsigned      NSTG     = 4,
  parameter logic [REG_W-1:0] BASE_REG = 5'd24,
  parameter int unsigned      LAT_W    = $clog2(NSTG+1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [REG_W-1:0]       in_src_a,
  input  logic [REG_W-1:0]       in_src_b,
  input  logic [REG_W-1:0]       in_dst,
  input  logic                   in_dual,
  input  logic [LAT_W-1:0]       in_lat,
  input  logic [DW-1:0]          in_imm,
  output logic [REG_W-1:0]       rf_ra_idx,
  output logic [REG_W-1:0]       rf_rb_idx,
  input  logic [DW-1:0]          rf_ra_data,
  input  logic [DW-1:0]          rf_rb_data,
  output logic                   rf_we,
  output logic [REG_W-1:0]       rf_wa,
  output logic [DW-1:0]          rf_wd,
  input  logic [NET_CNT-1:0]     nin_valid,
  output logic [NET_CNT-1:0]     nin_ready,
  input  logic [NET_CNT*DW-1:0]  nin_data,
  output logic [NET_CNT-1:0]     nout_valid,
  input  logic [NET_CNT-1:0]     nout_ready,
  output logic [NET_CNT*DW-1:0]  nout_data
);
  localparam int unsigned CW   = $clog2(DEPTH+1);
  localparam int unsigned SUMW = $clog2(DEPTH+NSTG+1) + 1;

  // input side
  logic [NET_CNT-1:0]         in_empty, in_pop;
  logic [NET_CNT-1:0][DW-1:0] in_head;
  logic [NET_CNT-1:0][CW-1:0] in_level;

  // output side
  logic [NET_CNT-1:0]           out_space, cap_want, cap_push;
  logic [NET_CNT-1:0][DW-1:0]   cap_data;
  logic [NET_CNT-1:0][CW-1:0]   out_level;
  logic [NET_CNT-1:0][SUMW-1:0] inflight, occ;

  // pipeline stages, index NSTG-1 is write-back (oldest)
  logic [NSTG-1:0]                 st_vld, st_rfwe, st_rdy;
  logic [NSTG-1:0][NET_CNT-1:0]    st_pend, clr_t;
  logic [NSTG-1:0][LAT_W-1:0]      st_lat;
  logic [NSTG-1:0][DW-1:0]         st_data;
  logic [NSTG-1:0][REG_W-1:0]      st_rfa;
  logic [NET_CNT-1:0][NSTG-1:0]    pend_col, cap_clr;

  // decode
  logic                dec_ok, rf_dst, issue;
  logic [NET_CNT-1:0]  need_mask, dst_mask;
  logic [DW-1:0]       result;
  logic [LAT_W-1:0]    lat_eff;

  netport_decode #(.DW(DW), .DEPTH(DEPTH), .SUMW(SUMW), .BASE_REG(BASE_REG)) u_dec (
    .src_a(in_src_a), .src_b(in_src_b), .dst(in_dst), .dual(in_dual), .imm(in_imm),
    .in_empty(in_empty), .in_head(in_head), .occ(occ),
    .rf_a_data(rf_ra_data), .rf_b_data(rf_rb_data),
    .ok(dec_ok), .need_mask(need_mask), .dst_mask(dst_mask),
    .rf_dst(rf_dst), .result(result)
  );

  assign in_ready  = dec_ok;
  assign issue     = in_valid && dec_ok;
  assign in_pop    = issue ? need_mask : '0;
  assign rf_ra_idx = in_src_a;
  assign rf_rb_idx = in_src_b;

  always_comb begin
    if (in_lat == '0)                 lat_eff = LAT_W'(1);
    else if (in_lat > LAT_W'(NSTG))   lat_eff = LAT_W'(NSTG);
    else                              lat_eff = in_lat;
  end

  genvar gk;
  generate
    for (gk = 0; gk < NET_CNT; gk++) begin : g_net
      netport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_in_q (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(nin_valid[gk]), .wr_ready(nin_ready[gk]), .wr_data(nin_data[gk*DW +: DW]),
        .rd_ready(in_pop[gk]), .rd_data(in_head[gk]), .level(in_level[gk])
      );
      assign in_empty[gk] = (in_level[gk] == '0);

      netport_capture #(.DW(DW), .NSTG(NSTG)) u_cap (
        .pend(pend_col[gk]), .rdy(st_rdy), .data(st_data), .space(out_space[gk]),
        .want(cap_want[gk]), .push(cap_push[gk]), .push_data(cap_data[gk]), .clr(cap_clr[gk])
      );

      netport_fifo #(.DW(DW), .DEPTH(DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(cap_push[gk]), .wr_ready(out_space[gk]), .wr_data(cap_data[gk]),
        .rd_ready(nout_ready[gk]), .rd_data(nout_data[gk*DW +: DW]), .level(out_level[gk])
      );
      assign nout_valid[gk] = (out_level[gk] != '0);
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NSTG; i++) begin
      st_rdy[i] = st_vld[i] && (st_lat[i] <= LAT_W'(i+1));
      for (int k = 0; k < NET_CNT; k++) begin
        pend_col[k][i] = st_pend[i][k];
        clr_t[i][k]    = cap_clr[k][i];
      end
    end
    for (int k = 0; k < NET_CNT; k++) begin
      inflight[k] = '0;
      for (int i = 0; i < NSTG; i++) inflight[k] = inflight[k] + SUMW'(st_pend[i][k]);
      occ[k] = SUMW'(out_level[k]) + inflight[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_vld  <= '0;
      st_pend <= '0;
      st_rfwe <= '0;
    end else begin
      st_vld[0]  <= issue;
      st_pend[0] <= issue ? dst_mask : '0;
      st_rfwe[0] <= issue && rf_dst;
      for (int i = 1; i < NSTG; i++) begin
        st_vld[i]  <= st_vld[i-1];
        st_pend[i] <= st_pend[i-1] & ~clr_t[i-1];
        st_rfwe[i] <= st_rfwe[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    st_lat[0]  <= lat_eff;
    st_data[0] <= result;
    st_rfa[0]  <= in_dst;
    for (int i = 1; i < NSTG; i++) begin
      st_lat[i]  <= st_lat[i-1];
      st_data[i] <= st_data[i-1];
      st_rfa[i]  <= st_rfa[i-1];
    end
  end

  assign rf_we = st_vld[NSTG-1] && st_rfwe[NSTG-1];
  assign rf_wa = st_rfa[NSTG-1];
  assign rf_wd = st_data[NSTG-1];
endmodule

// File: rtl/netport_regmap_chk.sv
`timescale 1ns/1ps
module netport_regmap_chk import netport_pkg::*; #(
  parameter int unsigned DW   = 32,
  parameter int unsigned NSTG = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [NET_CNT-1:0]    need_mask,
  input logic [NET_CNT-1:0]    in_empty,
  input logic [NET_CNT-1:0]    cap_want,
  input logic [NET_CNT-1:0]    out_space,
  input logic                  last_vld,
  input logic [NET_CNT-1:0]    last_pend,
  input logic [NET_CNT-1:0]    last_clr,
  input logic [NET_CNT-1:0]    nout_valid,
  input logic [NET_CNT-1:0]    nout_ready,
  input logic [NET_CNT*DW-1:0] nout_data
);
  p_empty_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((need_mask & in_empty) != '0)) |-> !in_ready);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cap_want & ~out_space) == '0));

  p_no_lost_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_vld |-> ((last_pend & ~last_clr) == '0));

  genvar gk;
  generate
    for (gk = 0; gk < NET_CNT; gk++) begin : g_hold
      p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (nout_valid[gk] && !nout_ready[gk]) |=>
          (nout_valid[gk] && $stable(nout_data[gk*DW +: DW])));
    end
  endgenerate
endmodule

bind netport_regmap netport_regmap_chk #(.DW(DW), .NSTG(NSTG)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .need_mask(need_mask), .in_empty(in_empty), .cap_want(cap_want), .out_space(out_space),
  .last_vld(st_vld[NSTG-1]), .last_pend(st_pend[NSTG-1]), .last_clr(clr_t[NSTG-1]),
  .nout_valid(nout_valid), .nout_ready(nout_ready), .nout_data(nout_data)
);

// File: tb/netport_regmap_bench.sv
`timescale 1ns/1ps
module netport_regmap_bench;
  localparam int DW = 32, DEPTH = 4, NSTG = 4, LAT_W = 3;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, in_dual = 0, in_ready;
  logic [4:0] in_src_a = 0, in_src_b = 0, in_dst = 0, rf_ra_idx, rf_rb_idx, rf_wa;
  logic [LAT_W-1:0] in_lat = 1;
  logic [DW-1:0] in_imm = 0, rf_ra_data, rf_rb_data, rf_wd;
  logic rf_we;
  logic [3:0] nin_valid, nin_ready, nout_valid, nout_ready;
  logic [4*DW-1:0] nin_data, nout_data;

  // stimulus sources for the network side
  logic feed_en = 0, pat_en = 0;
  logic [3:0] man_valid = 0, ready_mask = 0;
  logic [DW-1:0] man_data [4];
  logic [DW-1:0] fd [4];
  logic [7:0] pat_cnt;

  function automatic logic [DW-1:0] rfv(input logic [4:0] i);
    return 32'h0101_0101 * {27'd0, i} + 32'h0000_7000;
  endfunction
  assign rf_ra_data = rfv(rf_ra_idx);
  assign rf_rb_data = rfv(rf_rb_idx);

  always_comb begin
    for (int k = 0; k < 4; k++) nin_data[k*DW +: DW] = feed_en ? fd[k] : man_data[k];
  end
  assign nin_valid  = feed_en ? 4'hF : man_valid;
  assign nout_ready = pat_en ? (pat_cnt[3:0] ^ pat_cnt[7:4]) : ready_mask;

  always @(posedge clk) begin
    pat_cnt <= rst_n ? pat_cnt + 8'd7 : 8'd0;
    for (int k = 0; k < 4; k++) begin
      if (!rst_n) fd[k] <= {8'(k + 8'hC0), 24'd0};
      else if (feed_en && nin_ready[k]) fd[k] <= fd[k] + 1;
    end
  end

  netport_regmap u_netport_regmap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_dst(in_dst), .in_dual(in_dual),
    .in_lat(in_lat), .in_imm(in_imm),
    .rf_ra_idx(rf_ra_idx), .rf_rb_idx(rf_rb_idx), .rf_ra_data(rf_ra_data), .rf_rb_data(rf_rb_data),
    .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd),
    .nin_valid(nin_valid), .nin_ready(nin_ready), .nin_data(nin_data),
    .nout_valid(nout_valid), .nout_ready(nout_ready), .nout_data(nout_data)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference queue model
  logic [DW-1:0] inq [4][$];
  logic [DW-1:0] expq [4][$];
  logic [36:0]   exprf [$];

  always @(posedge clk) begin
    if (rst_n) begin
      if (in_valid && in_ready) begin
        int na, nb;
        bit am, bm;
        logic [DW-1:0] av, bv, res;
        int nd;
        bit dm;
        am = (in_src_a >= 24 && in_src_a <= 27); na = int'(in_src_a) - 24;
        bm = (in_src_b >= 24 && in_src_b <= 27); nb = int'(in_src_b) - 24;
        av = rfv(in_src_a); bv = rfv(in_src_b);
        if (am) begin
          if (inq[na].size() == 0) chk(0, "R3 issue with empty input model", 1, 0);
          else av = inq[na][0];
        end
        if (bm) begin
          if (inq[nb].size() == 0) chk(0, "R3 issue with empty input model", 1, 0);
          else bv = inq[nb][0];
        end
        if (am && inq[na].size() > 0) void'(inq[na].pop_front());
        if (bm && !(am && na == nb) && inq[nb].size() > 0) void'(inq[nb].pop_front());
        res = av ^ bv ^ in_imm;
        dm = (in_dst >= 24 && in_dst <= 27); nd = int'(in_dst) - 24;
        if (dm) expq[nd].push_back(res);
        if (in_dual && !(dm && nd == 0)) expq[0].push_back(res);
        if (!dm) exprf.push_back({in_dst, res});
      end
      for (int k = 0; k < 4; k++) begin
        if (nin_valid[k] && nin_ready[k]) inq[k].push_back(nin_data[k*DW +: DW]);
        if (nout_valid[k] && nout_ready[k]) begin
          if (expq[k].size() == 0) chk(0, "R8 unexpected output word", nout_data[k*DW +: DW], 0);
          else begin
            logic [DW-1:0] e;
            e = expq[k].pop_front();
            chk(nout_data[k*DW +: DW] == e, "R5/R8 output word order", nout_data[k*DW +: DW], e);
          end
        end
      end
      if (rf_we) begin
        if (exprf.size() == 0) chk(0, "R9 unexpected rf write", {rf_wa, rf_wd}, 0);
        else begin
          logic [36:0] e;
          e = exprf.pop_front();
          chk({rf_wa, rf_wd} == e, "R9 rf write", {rf_wa, rf_wd}, e);
        end
      end
    end
  end

  task automatic drive(input logic [4:0] sa, sb, d, input logic du, input logic [LAT_W-1:0] l,
                       input logic [DW-1:0] imm);
    in_valid = 1; in_src_a = sa; in_src_b = sb; in_dst = d; in_dual = du; in_lat = l; in_imm = imm;
  endtask

  // returns 1 ns after the accepting edge
  task automatic issue(input logic [4:0] sa, sb, d, input logic du, input logic [LAT_W-1:0] l,
                       input logic [DW-1:0] imm);
    drive(sa, sb, d, du, l, imm);
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  task automatic push_word(input int k, input logic [DW-1:0] w);
    man_valid[k] = 1; man_data[k] = w;
    @(posedge clk); #1;
    man_valid[k] = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) man_data[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk(nout_valid == 4'h0, "R10 reset nout_valid", nout_valid, 0);
    chk(nin_ready == 4'hF, "R10 reset nin_ready", nin_ready, 4'hF);
    chk(rf_we == 0, "R10 reset rf_we", rf_we, 0);
    @(posedge clk); #1;

    // R1: unmapped registers never stall on empty queues
    drive(5'd23, 5'd28, 5'd28, 0, 1, 32'h11);
    @(negedge clk);
    chk(in_ready == 1, "R1 unmapped sources no stall", in_ready, 1);
    @(posedge clk); #1 in_valid = 0;
    idle(NSTG + 1);

    // R7/R11: early capture cycle on every channel and latency
    ready_mask = 4'hF;
    for (int k = 0; k < 4; k++) begin
      for (int l = 0; l < 8; l++) begin
        int le;
        if (l == 5 || l == 6) continue;
        le = (l == 0) ? 1 : (l > NSTG ? NSTG : l);
        issue(5'd3, 5'd9, 5'(24 + k), 0, LAT_W'(l), 32'(k * 16 + l));
        repeat (le - 1) @(posedge clk);
        @(negedge clk);
        chk(nout_valid[k] == 0, "R7/R11 not visible before latency", nout_valid[k], 0);
        @(posedge clk); @(negedge clk);
        chk(nout_valid[k] == 1, "R7/R11 visible at latency", nout_valid[k], 1);
        idle(NSTG + 2);
      end
    end

    // R8: younger short-latency results wait behind older ones
    ready_mask = 4'h0;
    issue(5'd1, 5'd2, 5'd26, 0, 4, 32'hA0);
    issue(5'd1, 5'd2, 5'd26, 0, 1, 32'hA1);
    issue(5'd1, 5'd2, 5'd26, 1, 3, 32'hA2);
    idle(NSTG + 2);
    ready_mask = 4'hF;
    idle(8);

    // R4: output queue plus in-flight reaching DEPTH stalls issue
    ready_mask = 4'h0;
    for (int i = 0; i < DEPTH; i++) issue(5'd4, 5'd5, 5'd27, 0, 2, 32'(i + 8'h40));
    drive(5'd4, 5'd5, 5'd27, 0, 1, 32'h4F);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(in_ready == 0, "R4 stall on booked output queue", in_ready, 0);
    end
    @(posedge clk); #1 ready_mask = 4'h8;
    @(posedge clk); #1 ready_mask = 4'h0;
    @(negedge clk);
    chk(in_ready == 1, "R4 issue resumes after one pop", in_ready, 1);
    @(posedge clk); #1 in_valid = 0;
    ready_mask = 4'hF;
    idle(10);

    // R3: empty input queue stalls until a word arrives
    drive(5'd25, 5'd3, 5'd26, 0, 2, 32'h55);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(in_ready == 0, "R3 stall on empty input", in_ready, 0);
      chk(nout_valid == 0, "R3 nothing produced while stalled", nout_valid, 0);
    end
    @(posedge clk); #1;
    push_word(1, 32'hA5A5_0001);
    @(negedge clk);
    chk(in_ready == 1, "R3 issue after input word", in_ready, 1);
    @(posedge clk); #1 in_valid = 0;
    idle(8);

    // R2: same channel on both sources consumes one word
    push_word(2, 32'h1234_0001);
    push_word(2, 32'h1234_0002);
    issue(5'd26, 5'd26, 5'd25, 0, 1, 32'h77);
    issue(5'd26, 5'd1, 5'd25, 0, 2, 32'h78);
    drive(5'd26, 5'd1, 5'd25, 0, 2, 32'h79);
    @(negedge clk);
    chk(in_ready == 0, "R2 exactly one word per instruction", in_ready, 0);
    @(posedge clk); #1 in_valid = 0;
    idle(8);

    // R6: dual destination
    issue(5'd6, 5'd7, 5'd25, 1, 2, 32'hD1);
    issue(5'd6, 5'd7, 5'd24, 1, 3, 32'hD2);
    issue(5'd6, 5'd7, 5'd12, 1, 1, 32'hD3);
    idle(10);
    chk(expq[0].size() == 0 && expq[1].size() == 0, "R6 dual words delivered",
        expq[0].size() + expq[1].size(), 0);

    // R9: write-back timing
    issue(5'd2, 5'd3, 5'd7, 0, 1, 32'hBEEF);
    repeat (NSTG - 2) @(posedge clk);
    @(negedge clk);
    chk(rf_we == 0, "R9 no write before write-back", rf_we, 0);
    @(posedge clk); @(negedge clk);
    chk(rf_we == 1 && rf_wa == 5'd7, "R9 write-back cycle", {rf_we, rf_wa}, {1'b1, 5'd7});
    idle(4);

    // R10: full input queue
    man_valid[3] = 1;
    for (int i = 0; i < DEPTH; i++) begin
      man_data[3] = 32'h3300_0000 + 32'(i);
      @(posedge clk); #1;
    end
    @(negedge clk);
    chk(nin_ready[3] == 0, "R10 full input queue drops ready", nin_ready[3], 0);
    @(posedge clk); #1 man_valid[3] = 0;

    // sweep of register combinations under throttled consumers
    feed_en = 1; pat_en = 1;
    for (int d = 22; d < 30; d++)
      for (int s = 22; s < 30; s++)
        for (int du = 0; du < 2; du++)
          issue(5'(s), 5'(29 - s + 22), 5'(d), du[0], LAT_W'((d + s + du) % 6),
                32'(d * 97 + s * 13 + du));
    feed_en = 0; pat_en = 0; ready_mask = 4'hF;
    idle(40);
    for (int k = 0; k < 4; k++)
      chk(expq[k].size() == 0, "R8 all queued words delivered", expq[k].size(), 0);
    chk(exprf.size() == 0, "R9 all rf writes seen", exprf.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule